// File: doc/BRIEF.md
# Real-Time Clock Holding Register Freeze Control

This block keeps the software-visible copy of a real-time clock's time fields separate from the running timekeeping counters. While it is not frozen, the copy picks up the counter values on every one-second tick. Software can freeze the copy in two ways. A read freeze lets it read several bytes that all belong to the same second. A write freeze lets it overwrite the held fields with a new base time. The counters keep running in both cases. Only the copy stops.

When the write freeze is released, the block checks whether any held field was actually written during the freeze. If so, it raises a one-cycle load strobe that carries the held copy to the counters. If nothing was written, the counters are left alone. When the last freeze is released, the copy catches up with the counters without waiting for the next tick. The top field is the century, stored as two BCD digits (tens in the upper nibble, units in the lower nibble). A write to it that is not valid BCD is refused.

Top module: `rtc_hold_frz`

## Requirements
- R1: While reset is held, ctl_state is 2'b00, user_time is all zero and load_stb is 0.
- R2: When neither freeze is set, a cycle with sec_tick=1 copies cnt_time into user_time, visible from the next cycle. A cycle without a tick leaves user_time unchanged.
- R3: While the read freeze (ctl_state bit 0) is 1, user_time ignores sec_tick and cnt_time. The read freeze needs no write freeze and does not enable field writes.
- R4: While the write freeze (ctl_state bit 1) is 1, fld_we=1 writes fld_wdata into field fld_sel, visible the next cycle. Field i occupies user_time[8i+7:8i], with the century at index 7. A select of 8 or above changes nothing.
- R5: A field write while the write freeze is 0 changes nothing.
- R6: If the write freeze goes from 1 to 0 after at least one accepted field write during the freeze, load_stb is 1 for exactly the next cycle. In that cycle load_time equals the held copy, including a write accepted in the same cycle as the release.
- R7: If the write freeze goes from 1 to 0 with no accepted field write during the freeze, load_stb stays 0.
- R8: The modification record is cleared when the write freeze falls. A later write freeze with no writes produces no load.
- R9: When both freezes reach 0 and no load follows, the copy takes the counters sampled in the cycle after the release, with no tick needed. After a load, the copy skips the strobe cycle and takes the counters in the cycle after it.
- R10: A write to the century field is accepted only when both nibbles are 9 or less. A refused write changes nothing and does not count as a modification.
- R11: ctl_we=1 loads ctl_wdata into the control state, visible the next cycle: bit 1 is the write freeze and bit 0 is the read freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-second tick from the counters |
| cnt_time | input | NUM_FIELDS*8 | Current counter values, one byte per field |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 2 | {write freeze, read freeze} |
| ctl_state | output | 2 | Current {write freeze, read freeze} |
| fld_we | input | 1 | Time field write strobe |
| fld_sel | input | $clog2(NUM_FIELDS)+1 | Field index |
| fld_wdata | input | 8 | Field write data |
| user_time | output | NUM_FIELDS*8 | Software-visible held copy |
| load_stb | output | 1 | One-cycle load request to the counters |
| load_time | output | NUM_FIELDS*8 | Time to load, valid with load_stb |

## Verification
The assertions assume that the external counters take load_time during the strobe cycle and present it from the following cycle. They also assume that cnt_time only settles to new values on tick cycles or after a load. The bench drives cnt_time by hand, giving it the loaded value right after a strobe, so that assumption holds. Strobes and control writes are applied one cycle at a time, away from the clock edge.

// File: rtl/rtc_frz_pkg.sv
package rtc_frz_pkg;

  localparam int unsigned FLD_W = 8;

  // Field order inside the held copy; the century must stay last.
  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_WDAY = 3'd3,
    FLD_MDAY = 3'd4,
    FLD_MON  = 3'd5,
    FLD_YEAR = 3'd6,
    FLD_CENT = 3'd7
  } fld_idx_e;

  function automatic logic bcd_pair_ok(input logic [FLD_W-1:0] v);
    return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
  endfunction

endpackage

// File: rtl/rtc_frz_rst_sync.sv
module rtc_frz_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/rtc_frz_ctl.sv
module rtc_frz_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       ctl_we,
  input  logic [1:0] ctl_wdata,
  input  logic       wr_hit,
  output logic       rd_frz,
  output logic       wr_frz,
  output logic       upd_en,
  output logic       load_stb
);

  logic rd_q, wr_q, mod_q, resync_q, load_q;
  logic rd_nxt, wr_nxt, mod_nxt, resync_nxt, load_nxt;
  logic wr_fall, frz_now, frz_next, release_now;

  always_comb begin
    rd_nxt      = ctl_we ? ctl_wdata[0] : rd_q;
    wr_nxt      = ctl_we ? ctl_wdata[1] : wr_q;
    wr_fall     = wr_q & ~wr_nxt;
    frz_now     = rd_q | wr_q;
    frz_next    = rd_nxt | wr_nxt;
    release_now = frz_now & ~frz_next;
    upd_en      = ~frz_now & ~load_q & (sec_tick | resync_q);
    load_nxt    = wr_fall & (mod_q | wr_hit);
    mod_nxt     = wr_fall ? 1'b0 : (mod_q | wr_hit);
    if (release_now) begin
      resync_nxt = 1'b1;
    end else if (upd_en) begin
      resync_nxt = 1'b0;
    end else begin
      resync_nxt = resync_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      mod_q    <= 1'b0;
      resync_q <= 1'b0;
      load_q   <= 1'b0;
    end else begin
      rd_q     <= rd_nxt;
      wr_q     <= wr_nxt;
      mod_q    <= mod_nxt;
      resync_q <= resync_nxt;
      load_q   <= load_nxt;
    end
  end

  assign rd_frz   = rd_q;
  assign wr_frz   = wr_q;
  assign load_stb = load_q;

  // R6
  load_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> (!wr_q && $past(wr_q)));

  // R8
  mod_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> !mod_q);

  // R7
  no_idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && ctl_we && !ctl_wdata[1] && !mod_q && !wr_hit) |=> !load_stb);

  // R9
  skip_load_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> !upd_en);

endmodule

// File: rtl/rtc_frz_field.sv
module rtc_frz_field
  import rtc_frz_pkg::*;
#(
  parameter bit BCD_ONLY = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [FLD_W-1:0] cnt_byte,
  input  logic             wr_en,
  input  logic [FLD_W-1:0] wdata,
  output logic             accept,
  output logic [FLD_W-1:0] q
);

  logic [FLD_W-1:0] q_r, q_nxt;
  logic             data_ok;

  generate
    if (BCD_ONLY) begin : g_bcd
      assign data_ok = bcd_pair_ok(wdata);
    end else begin : g_raw
      assign data_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    accept = wr_en & data_ok;
    if (accept) begin
      q_nxt = wdata;
    end else if (upd_en) begin
      q_nxt = cnt_byte;
    end else begin
      q_nxt = q_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !accept) |=> $stable(q));

  // R2
  follow_counter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !wr_en) |=> (q == $past(cnt_byte)));

  // R10
  refuse_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !data_ok && !upd_en) |=> $stable(q));

endmodule

// File: rtl/rtc_hold_frz.sv
module rtc_hold_frz
  import rtc_frz_pkg::*;
#(
  parameter int unsigned NUM_FIELDS = 8,
  parameter int unsigned CENT_IDX   = 7,
  localparam int unsigned SEL_W     = $clog2(NUM_FIELDS) + 1,
  localparam int unsigned TIME_W    = NUM_FIELDS * FLD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [TIME_W-1:0] cnt_time,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_wdata,
  output logic [1:0]        ctl_state,
  input  logic              fld_we,
  input  logic [SEL_W-1:0]  fld_sel,
  input  logic [FLD_W-1:0]  fld_wdata,
  output logic [TIME_W-1:0] user_time,
  output logic              load_stb,
  output logic [TIME_W-1:0] load_time
);

  logic                  srst_n;
  logic                  rd_frz, wr_frz, upd_en, wr_hit;
  logic [NUM_FIELDS-1:0] acc_vec;

  rtc_frz_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  rtc_frz_ctl u_ctl (
    .clk       (clk),
    .rst_n     (srst_n),
    .sec_tick  (sec_tick),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .wr_hit    (wr_hit),
    .rd_frz    (rd_frz),
    .wr_frz    (wr_frz),
    .upd_en    (upd_en),
    .load_stb  (load_stb)
  );

  generate
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
      logic sel_hit;
      assign sel_hit = fld_we & wr_frz & (fld_sel == SEL_W'(i));
      rtc_frz_field #(
        .BCD_ONLY (i == CENT_IDX)
      ) u_fld (
        .clk      (clk),
        .rst_n    (srst_n),
        .upd_en   (upd_en),
        .cnt_byte (cnt_time[i*FLD_W +: FLD_W]),
        .wr_en    (sel_hit),
        .wdata    (fld_wdata),
        .accept   (acc_vec[i]),
        .q        (user_time[i*FLD_W +: FLD_W])
      );
    end
  endgenerate

  assign wr_hit    = |acc_vec;
  assign ctl_state = {wr_frz, rd_frz};
  assign load_time = user_time;

  // R5
  locked_write_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (fld_we && !wr_frz && !upd_en) |=> $stable(user_time));

  // R4
  single_field_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(acc_vec) <= 1);

  // R6
  load_data_stable_chk: assert property (@(posedge clk) disable iff (!srst_n)
    load_stb |=> $stable(user_time) || !$past(rd_frz) || $past(wr_hit));

endmodule

// File: tb/rtc_hold_frz_bench.sv
`timescale 1ns/1ps
module rtc_hold_frz_bench;

  localparam int NF = 8;
  localparam int TW = NF * 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sec_tick;
  logic [TW-1:0] cnt_time;
  logic          ctl_we;
  logic [1:0]    ctl_wdata;
  logic [1:0]    ctl_state;
  logic          fld_we;
  logic [3:0]    fld_sel;
  logic [7:0]    fld_wdata;
  logic [TW-1:0] user_time;
  logic          load_stb;
  logic [TW-1:0] load_time;

  int n_chk  = 0;
  int n_fail = 0;
  logic [TW-1:0] exp_u;

  always #2 clk = ~clk;

  rtc_hold_frz u_rtc_hold_frz (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cnt_time(cnt_time),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_state(ctl_state),
    .fld_we(fld_we), .fld_sel(fld_sel), .fld_wdata(fld_wdata),
    .user_time(user_time), .load_stb(load_stb), .load_time(load_time)
  );

  task automatic chk(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clk1;
    @(posedge clk);
    #1;
    ctl_we   = 1'b0;
    fld_we   = 1'b0;
    sec_tick = 1'b0;
  endtask

  task automatic set_ctl(input logic [1:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    clk1();
  endtask

  task automatic wr_fld(input int s, input logic [7:0] v);
    fld_we = 1'b1; fld_sel = 4'(s); fld_wdata = v;
    clk1();
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sec_tick = 0; cnt_time = '0; ctl_we = 0; ctl_wdata = 0;
    fld_we = 0; fld_sel = 0; fld_wdata = 0;
    repeat (3) clk1();
    chk("R1 ctl", TW'(ctl_state), '0);
    chk("R1 user", user_time, '0);
    chk("R1 load", TW'(load_stb), '0);
    rst_n = 1'b1;
    repeat (3) clk1();

    // R2: tick copies, no tick holds
    cnt_time = 64'h2099_1231_0623_5958; sec_tick = 1; clk1();
    exp_u = 64'h2099_1231_0623_5958;
    chk("R2 tick", user_time, exp_u);
    cnt_time = 64'h2100_0101_0700_0000; clk1();
    chk("R2 no tick", user_time, exp_u);

    // R11 / R3: read freeze only
    set_ctl(2'b01);
    chk("R11 rd set", TW'(ctl_state), 64'h1);
    for (int k = 0; k < 3; k++) begin
      cnt_time = 64'h2100_0101_0700_0010 + 64'(k); sec_tick = 1; clk1();
    end
    chk("R3 frozen", user_time, exp_u);
    wr_fld(0, 8'h44);
    chk("R3 R5 no write under read freeze", user_time, exp_u);
    set_ctl(2'b00);
    chk("R11 cleared", TW'(ctl_state), '0);
    chk("R7 no load on read release", TW'(load_stb), '0);
    chk("R9 not yet", user_time, exp_u);
    cnt_time = 64'h2100_0101_0700_0033; clk1();
    chk("R9 resync", user_time, 64'h2100_0101_0700_0033);
    exp_u = 64'h2100_0101_0700_0033;

    // R5: write with no freeze
    wr_fld(1, 8'h11);
    chk("R5 ignored", user_time, exp_u);

    // R4 sweep of selects under write freeze
    set_ctl(2'b10);
    chk("R11 wr set", TW'(ctl_state), 64'h2);
    cnt_time = 64'h0; sec_tick = 1; clk1();
    chk("R3 write freeze holds", user_time, exp_u);
    for (int s = 0; s < 16; s++) begin
      if (s < NF) exp_u[s*8 +: 8] = 8'h40 + 8'(s);
      wr_fld(s, 8'h40 + 8'(s));
      chk($sformatf("R4 sel %0d", s), user_time, exp_u);
    end

    // R6: release with a write in the same cycle
    ctl_we = 1; ctl_wdata = 2'b00; fld_we = 1; fld_sel = 1; fld_wdata = 8'h33;
    exp_u[15:8] = 8'h33;
    clk1();
    chk("R6 strobe", TW'(load_stb), 64'h1);
    chk("R6 data", load_time, exp_u);
    cnt_time = exp_u + 64'h5;
    clk1();
    chk("R6 one cycle", TW'(load_stb), '0);
    chk("R9 skip strobe cycle", user_time, exp_u);
    clk1();
    chk("R9 after load", user_time, exp_u + 64'h5);
    exp_u = exp_u + 64'h5;

    // R7 / R8: empty freeze session
    set_ctl(2'b10);
    set_ctl(2'b00);
    chk("R7 R8 no load", TW'(load_stb), '0);
    clk1();
    chk("R7 still none", TW'(load_stb), '0);

    // R10: century sweep
    set_ctl(2'b10);
    for (int v = 0; v < 256; v++) begin
      if ((v[7:4] <= 9) && (v[3:0] <= 9)) exp_u[63:56] = 8'(v);
      wr_fld(7, 8'(v));
      chk($sformatf("R10 cent %02h", v), user_time, exp_u);
    end
    set_ctl(2'b00);
    chk("R10 valid load", TW'(load_stb), 64'h1);
    chk("R10 load data", load_time, exp_u);
    cnt_time = exp_u; clk1(); clk1();

    // R10: only refused write -> no load
    set_ctl(2'b10);
    wr_fld(7, 8'hA5);
    chk("R10 refused", user_time, exp_u);
    set_ctl(2'b00);
    chk("R10 no mod", TW'(load_stb), '0);
    clk1(); clk1();

    // Both freezes; drop write, keep read
    set_ctl(2'b11);
    wr_fld(2, 8'h09);
    exp_u[23:16] = 8'h09;
    set_ctl(2'b01);
    chk("R6 load under read freeze", TW'(load_stb), 64'h1);
    chk("R6 data under read freeze", load_time, exp_u);
    cnt_time = exp_u + 64'h100;
    for (int k = 0; k < 3; k++) begin sec_tick = 1; clk1(); end
    chk("R3 still read frozen", user_time, exp_u);
    set_ctl(2'b00);
    clk1();
    chk("R9 final resync", user_time, exp_u + 64'h100);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule